// File: doc/BRIEF.md
# Two-Step Acquisition Hand-Over Controller

This block runs the two-step acquisition of a clock-recovery loop that uses a single oscillator. It counts rising edges of the divided oscillator clock over a fixed window of reference-clock cycles. The count is held in a Gray-coded counter in the divided-clock domain and synchronised into the reference domain. The block then compares the count against the window length to judge the frequency error.

The block starts in frequency acquisition, with only the frequency loop enabled. It moves to phase tracking after two consecutive windows inside a tight error band. In phase tracking it keeps measuring. It falls back to frequency acquisition after two consecutive windows outside a wider band. The gap between the two bands gives hysteresis.

Every change of mode raises a one-cycle hand-over strobe, so that the external switch logic can sequence its transfer. All outputs are registered in the reference domain.

Top module: `acq_handover_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, freq_loop_en is 1 and phase_loop_en, locked and handover_stb are 0.
- R2: The error of each window is |N − WIN_LEN|, where N is the number of divided-clock rising edges seen during WIN_LEN reference cycles. The error is symmetric, so a divided clock that runs fast and one that runs slow are treated alike. The first window after reset is discarded.
- R3: In frequency mode, two consecutive windows with error ≤ LOCK_TOL (default 4) switch the block to phase mode: phase_loop_en=1, locked=1, freq_loop_en=0.
- R4: In frequency mode, windows with error above LOCK_TOL but at most UNLOCK_TOL never produce lock.
- R5: In phase mode, windows with error ≤ UNLOCK_TOL (default 16) keep the lock.
- R6: In phase mode, two consecutive windows with error > UNLOCK_TOL return the block to frequency mode: freq_loop_en=1, phase_loop_en=0, locked=0.
- R7: A single out-of-band window that is followed by in-band windows does not change the mode.
- R8: Exactly one of freq_loop_en and phase_loop_en is high in every cycle.
- R9: handover_stb is high for exactly one reference cycle at each mode change, and at no other time.
- R10: The mode changes only on the cycle after a window closes. All mode changes are therefore a whole number of windows apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all outputs are in this domain |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| div_clk | input | 1 | Divided oscillator clock |
| div_rst_n | input | 1 | Synchronous active-low reset, divided-clock domain |
| freq_loop_en | output | 1 | Enable for the frequency-acquisition loop |
| phase_loop_en | output | 1 | Enable for the data phase loop |
| locked | output | 1 | Lock status (phase mode active) |
| handover_stb | output | 1 | One-cycle pulse at each mode change |

## Verification
The bench steps the divided-clock offset through three kinds of value: above the unlock band, inside the hysteresis band, and inside the lock band, on both the fast and the slow side.

A design without hysteresis would lock at a 1500 ppm offset, or drop lock there. A design without two-window confirmation would drop lock on a short frequency burst. A design that uses a signed rather than an absolute error would never lock, or never unlock, on one side.

Strobe pulses are counted and their spacing is checked against the window length. This catches missing strobes, doubled strobes and mode changes outside window boundaries.

// File: rtl/acq_pkg.sv
// Shared types for the acquisition hand-over controller.
package acq_pkg;
    typedef enum logic {MODE_FREQ = 1'b0, MODE_PHASE = 1'b1} acq_mode_t;
endpackage

// File: rtl/div_gray_counter.sv
// Free-running edge counter in the divided-clock domain, published in Gray code.
// Assumes the reader samples the Gray value with a multi-flop synchroniser.
module div_gray_counter #(
    parameter int CW = 16
) (
    input  logic          div_clk,
    input  logic          div_rst_n,
    output logic [CW-1:0] gray_q
);
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nxt;

    // Next binary count.
    always_comb bin_nxt = bin_q + 1'b1;

    // Count divided-clock edges; register the Gray form so only one bit moves per edge.
    always_ff @(posedge div_clk) begin
        if (!div_rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end
endmodule

// File: rtl/gray_sync.sv
// Synchronises a Gray-coded count into the reference domain and converts it to binary.
// Assumes the source changes at most one bit between reference samples.
module gray_sync #(
    parameter int CW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] gray_in,
    output logic [CW-1:0] bin_out
);
    logic [CW-1:0] stg_q [STAGES];

    // Synchroniser chain, one flop row per stage.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= (s == 0) ? gray_in : stg_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Gray to binary conversion.
    always_comb begin
        bin_out[CW-1] = stg_q[STAGES-1][CW-1];
        for (int i = CW - 2; i >= 0; i--)
            bin_out[i] = bin_out[i+1] ^ stg_q[STAGES-1][i];
    end
endmodule

// File: rtl/window_meter.sv
// Closes a window every WIN_LEN reference cycles and reports the edge count seen in it.
// The first window after reset is discarded because its start point is undefined.
module window_meter #(
    parameter int CW      = 16,
    parameter int WIN_LEN = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] edge_total,
    output logic          meas_valid,
    output logic [CW-1:0] meas_count
);
    localparam int WW = $clog2(WIN_LEN);
    localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

    logic [WW-1:0] win_q;
    logic [CW-1:0] snap_q;
    logic          primed_q;
    logic          win_end;

    // Window boundary detect.
    always_comb win_end = (win_q == LAST);

    // Window timer, snapshot and per-window difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= '0;
            snap_q     <= '0;
            primed_q   <= 1'b0;
            meas_valid <= 1'b0;
            meas_count <= '0;
        end else begin
            meas_valid <= 1'b0;
            if (win_end) begin
                win_q      <= '0;
                snap_q     <= edge_total;
                primed_q   <= 1'b1;
                meas_valid <= primed_q;
                meas_count <= edge_total - snap_q;
            end else begin
                win_q <= win_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lock_fsm.sv
// Two-mode hand-over machine with hysteresis and consecutive-window confirmation.
// Assumes meas_valid is a single-cycle pulse per closed window.
module lock_fsm
    import acq_pkg::*;
#(
    parameter int CW         = 16,
    parameter int WIN_LEN    = 4096,
    parameter int LOCK_TOL   = 4,
    parameter int UNLOCK_TOL = 16,
    parameter int CONFIRM    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          meas_valid,
    input  logic [CW-1:0] meas_count,
    output logic          freq_en,
    output logic          phase_en,
    output logic          lock_flag,
    output logic          stb
);
    localparam int SW = $clog2(CONFIRM + 1);
    localparam logic [CW:0]   TARGET = (CW+1)'(WIN_LEN);
    localparam logic [CW:0]   LK_LIM = (CW+1)'(LOCK_TOL);
    localparam logic [CW:0]   UL_LIM = (CW+1)'(UNLOCK_TOL);
    localparam logic [SW-1:0] STREAK_LAST = SW'(CONFIRM - 1);

    acq_mode_t     mode_q, mode_nxt;
    logic [SW-1:0] streak_q, streak_nxt;
    logic [CW:0]   ext_cnt, err;
    logic          qualifies;

    // Absolute error and whether this window counts toward a mode change.
    always_comb begin
        ext_cnt   = {1'b0, meas_count};
        err       = (ext_cnt >= TARGET) ? (ext_cnt - TARGET) : (TARGET - ext_cnt);
        qualifies = (mode_q == MODE_FREQ) ? (err <= LK_LIM) : (err > UL_LIM);
    end

    // Next mode and confirmation streak.
    always_comb begin
        mode_nxt   = mode_q;
        streak_nxt = streak_q;
        if (meas_valid) begin
            if (!qualifies) begin
                streak_nxt = '0;
            end else if (streak_q == STREAK_LAST) begin
                streak_nxt = '0;
                mode_nxt   = (mode_q == MODE_FREQ) ? MODE_PHASE : MODE_FREQ;
            end else begin
                streak_nxt = streak_q + 1'b1;
            end
        end
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_FREQ;
            streak_q  <= '0;
            freq_en   <= 1'b1;
            phase_en  <= 1'b0;
            lock_flag <= 1'b0;
            stb       <= 1'b0;
        end else begin
            mode_q    <= mode_nxt;
            streak_q  <= streak_nxt;
            freq_en   <= (mode_nxt == MODE_FREQ);
            phase_en  <= (mode_nxt == MODE_PHASE);
            lock_flag <= (mode_nxt == MODE_PHASE);
            stb       <= (mode_nxt != mode_q);
        end
    end
endmodule

// File: rtl/acq_handover_ctrl.sv
// Top: measures divided-clock frequency against the reference and sequences the
// frequency and phase loops. Assumes div_clk is no faster than about twice ref_clk.
module acq_handover_ctrl #(
    parameter int CW         = 16,
    parameter int WIN_LEN    = 4096,
    parameter int LOCK_TOL   = 4,
    parameter int UNLOCK_TOL = 16,
    parameter int CONFIRM    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic div_clk,
    input  logic div_rst_n,
    output logic freq_loop_en,
    output logic phase_loop_en,
    output logic locked,
    output logic handover_stb
);
    logic [CW-1:0] gray_cnt;
    logic [CW-1:0] edge_total;
    logic [CW-1:0] meas_count;
    logic          meas_valid;

    div_gray_counter #(.CW(CW)) u_cnt (
        .div_clk(div_clk), .div_rst_n(div_rst_n), .gray_q(gray_cnt));

    gray_sync #(.CW(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(ref_clk), .rst_n(ref_rst_n), .gray_in(gray_cnt), .bin_out(edge_total));

    window_meter #(.CW(CW), .WIN_LEN(WIN_LEN)) u_win (
        .clk(ref_clk), .rst_n(ref_rst_n), .edge_total(edge_total),
        .meas_valid(meas_valid), .meas_count(meas_count));

    lock_fsm #(.CW(CW), .WIN_LEN(WIN_LEN), .LOCK_TOL(LOCK_TOL),
               .UNLOCK_TOL(UNLOCK_TOL), .CONFIRM(CONFIRM)) u_fsm (
        .clk(ref_clk), .rst_n(ref_rst_n), .meas_valid(meas_valid),
        .meas_count(meas_count), .freq_en(freq_loop_en), .phase_en(phase_loop_en),
        .lock_flag(locked), .stb(handover_stb));
endmodule

// File: rtl/acq_handover_chk.sv
// Property checker for acq_handover_ctrl, attached by bind below.
module acq_handover_chk (
    input logic clk,
    input logic rst_n,
    input logic meas_valid,
    input logic freq_en,
    input logic phase_en,
    input logic locked,
    input logic stb
);
    a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        freq_en ^ phase_en);
    a_r9_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);
    a_r9_change_has_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en != $past(phase_en)) |-> stb);
    a_r9_stb_has_change: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (phase_en != $past(phase_en)));
    a_r10_change_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(meas_valid) |-> $stable(phase_en));
    a_r3_status_matches: assert property (@(posedge clk) disable iff (!rst_n)
        locked == phase_en);
endmodule

bind acq_handover_ctrl acq_handover_chk u_chk (
    .clk(ref_clk), .rst_n(ref_rst_n), .meas_valid(meas_valid),
    .freq_en(freq_loop_en), .phase_en(phase_loop_en),
    .locked(locked), .stb(handover_stb));

// File: tb/tb_acq_handover_ctrl.sv
`timescale 1ns/1ps
module tb_acq_handover_ctrl;
    localparam int WIN   = 4096;
    localparam int LIMIT = 195000;
    localparam int NROWS = 8;
    // offset of divided clock in ppm (positive = slower), expected lock after settling
    localparam int ROW_PPM  [NROWS] = '{20000, 1500, 0, 1500, -20000, -500, 8000, 0};
    localparam bit ROW_LOCK [NROWS] = '{0, 0, 1, 1, 0, 1, 0, 1};

    logic ref_clk = 1'b0, div_clk = 1'b0, rst_n = 1'b0;
    logic freq_loop_en, phase_loop_en, locked, handover_stb;
    real  ppm = 20000.0;
    int   checks = 0, errors = 0, cyc = 0;
    int   stb_count = 0, stb_double = 0, excl_bad = 0, first_stb = -1, off_grid = 0;
    bit   prev_stb = 1'b0, done = 1'b0;

    acq_handover_ctrl dut (
        .ref_clk(ref_clk), .ref_rst_n(rst_n), .div_clk(div_clk), .div_rst_n(rst_n),
        .freq_loop_en(freq_loop_en), .phase_loop_en(phase_loop_en),
        .locked(locked), .handover_stb(handover_stb));

    always #4 ref_clk = ~ref_clk;
    always #(4.0 * (1.0 + ppm * 1.0e-6)) div_clk = ~div_clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor outputs between edges: exclusivity, strobe width and window alignment.
    always @(negedge ref_clk) begin
        if (rst_n) begin
            if (freq_loop_en == phase_loop_en) excl_bad++;
            if (handover_stb) begin
                stb_count++;
                if (prev_stb) stb_double++;
                if (first_stb < 0) first_stb = cyc;
                else if (((cyc - first_stb) % WIN) != 0) off_grid++;
            end
            prev_stb = handover_stb;
        end
    end

    // Cycle count and watchdog.
    always @(posedge ref_clk) begin
        cyc++;
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (10) @(negedge ref_clk);
        // R1: reset state
        check("R1 freq_en", int'(freq_loop_en), 1);
        check("R1 phase_en", int'(phase_loop_en), 0);
        check("R1 locked", int'(locked), 0);
        check("R1 stb", int'(handover_stb), 0);
        rst_n = 1'b1;
        @(negedge ref_clk);
        check("R1 after release", int'(freq_loop_en), 1);

        // Table walk: R2 symmetric error, R3 lock, R4/R5 hysteresis, R6 unlock
        for (int r = 0; r < NROWS; r++) begin
            ppm = real'(ROW_PPM[r]);
            repeat (4 * WIN) @(negedge ref_clk);
            check($sformatf("R3/R4/R5/R6/R2 row%0d locked", r), int'(locked), int'(ROW_LOCK[r]));
            check($sformatf("R8 row%0d phase_en", r), int'(phase_loop_en), int'(ROW_LOCK[r]));
            check($sformatf("R8 row%0d freq_en", r), int'(freq_loop_en), int'(!ROW_LOCK[r]));
        end

        // R9: one strobe per mode change (5 changes in the table)
        check("R9 strobe count", stb_count, 5);

        // R7: short burst can push at most one window out of band
        ppm = 50000.0;
        repeat (600) @(negedge ref_clk);
        ppm = 0.0;
        repeat (3 * WIN) @(negedge ref_clk);
        check("R7 still locked", int'(locked), 1);
        check("R7 no strobe", stb_count, 5);

        check("R9 strobe width", stb_double, 0);
        check("R8 exclusivity", excl_bad, 0);
        check("R10 window aligned changes", off_grid, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule